// File: doc/BRIEF.md
# NAND Flash Device Command and Column Pointer Front End

This block is the device-side front end of a small-page NAND flash. All command, address and data traffic arrives over one shared byte bus. The block samples the bus strobes on its own clock. A rising write strobe is steered by the command-latch and address-latch inputs into a command decode, an address sequencer or the page buffer. A falling read strobe shifts one byte out of the page buffer.

An internal column pointer walks through a 528-byte page buffer. Columns 512 to 527 form the spare area. The read command code chooses which half of the page the pointer starts in. The low column byte given on the bus supplies the rest of the start column. Program, erase and the array fetch of a read are not modelled physically. Each one holds the ready/busy output low for a parameterised number of cycles.

The block serves as a self-checking target for a host-side NAND sequencer.

Top module: `nand_front_end`

## Requirements
- R1: After reset, `rb` is 1 (ready) and `io_oe` is 0.
- R2: Read command 00h makes the start column equal to the column address byte. Read command 01h makes it 256 plus that byte. Program setup 80h uses the half chosen by the most recent read command, and that half is 0 after reset.
- R3: In the read data phase, with the device ready and `ce_n` low, each falling edge of `re_n` puts the byte at the current column on `io_out` from the next clock on. It then advances the column by one.
- R4: Address cycles come in the order column, row low, row high. A read or program takes three of them and an erase takes two. Any further address cycles leave the column pointer unchanged.
- R5: A command, address or data byte is captured on a rising edge of `we_n` only while `ce_n` is low. `cle`=1 selects a command, `ale`=1 selects an address, and both low select data. With `ce_n` high, write strobes have no effect.
- R6: `io_oe` is 1 only while `ce_n` is low, `re_n` is low, the block is in the read data phase and `rb` is 1.
- R7: `rb` goes low for exactly T_READ cycles after the third read address cycle. It goes low for T_PROG cycles after 10h ends a program, and for T_ERASE cycles after D0h ends an erase. Raising `ce_n` during busy does not shorten the interval.
- R8: While `wp_n` is 0, the commands 80h, 10h, 60h and D0h have no effect. `rb` stays 1 and the page contents are unchanged.
- R9: When the pointer steps past column 527, it wraps to column 0 and the row address increments.
- R10: Data bytes after 80h and its address cycles are stored at consecutive columns from the start column. An erase (60h, two row cycles, D0h) sets every page byte to FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Bus byte is a command |
| ale | input | 1 | Bus byte is an address |
| we_n | input | 1 | Write strobe; capture on rising edge |
| re_n | input | 1 | Read strobe; shift out on falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte bus, host to device |
| io_out | output | 8 | Byte bus, device to host |
| io_oe | output | 1 | Output driver enable; 0 means high impedance |
| rb | output | 1 | 1 = ready, 0 = busy; always driven |

## Verification
The assertions check the following on every cycle:
- the column pointer stays inside the page;
- each read or data step advances the pointer by one or wraps it to 0, with a row increment on the wrap;
- surplus address cycles leave the pointer still;
- no output is enabled while busy;
- a new busy interval never starts over a running one;
- write protect keeps program and erase setup from being entered.

Only the bench scenarios can show the following:
- the real byte values in the two page halves;
- the exact busy lengths, including the case with chip select raised;
- that protected or deselected command sequences leave the stored page untouched.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  typedef enum logic [7:0] {
    OP_READ_LO   = 8'h00,
    OP_READ_HI   = 8'h01,
    OP_LOAD      = 8'h80,
    OP_PROGRAM   = 8'h10,
    OP_ERASE_SET = 8'h60,
    OP_ERASE_GO  = 8'hD0
  } op_code_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD_ADDR,
    PH_RD_DATA,
    PH_PG_ADDR,
    PH_PG_DATA,
    PH_ER_ADDR
  } phase_e;

endpackage

// File: rtl/nand_bus_decode.sv
module nand_bus_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic cle,
  input  logic ale,
  input  logic we_n,
  input  logic re_n,
  output logic ev_cmd,
  output logic ev_addr,
  output logic ev_din,
  output logic ev_rd
);
  logic we_q, re_q;
  logic we_rise, re_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  assign we_rise = ~we_q & we_n & ~ce_n;
  assign re_fall = re_q & ~re_n & ~ce_n;

  assign ev_cmd  = we_rise & cle & ~ale;
  assign ev_addr = we_rise & ale & ~cle;
  assign ev_din  = we_rise & ~cle & ~ale;
  assign ev_rd   = re_fall;
endmodule

// File: rtl/nand_col_ptr.sv
module nand_col_ptr #(
  parameter int PAGE_BYTES = 528,
  parameter int HALF_BYTES = 256,
  parameter int COL_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             half,
  input  logic [7:0]       lo,
  input  logic             step,
  output logic [COL_W-1:0] col,
  output logic             wrap
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  function automatic logic [COL_W-1:0] start_col(input logic h, input logic [7:0] a);
    return h ? COL_W'(HALF_BYTES) + COL_W'(a) : COL_W'(a);
  endfunction

  function automatic logic [COL_W-1:0] next_col(input logic [COL_W-1:0] c);
    return (c == LAST_COL) ? '0 : c + 1'b1;
  endfunction

  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    col_q <= '0;
    else if (load) col_q <= start_col(half, lo);
    else if (step) col_q <= next_col(col_q);
  end

  assign col  = col_q;
  assign wrap = step & ~load & (col_q == LAST_COL);

  // R2: the pointer never leaves the page
  a_r2_col_range: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= LAST_COL);

  // R3, R9: a step moves the pointer by one or wraps it to column 0
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ((col_q == $past(col_q) + 1'b1) ||
                         ($past(col_q) == LAST_COL && col_q == '0)));
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R7: the controller never restarts a running interval
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
  parameter int DEPTH = 528,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (clear) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= mem[addr];
  end
endmodule

// File: rtl/nand_front_end.sv
module nand_front_end
  import nand_fe_pkg::*;
#(
  parameter int PAGE_BYTES = 528,
  parameter int HALF_BYTES = 256,
  parameter int ROW_W      = 16,
  parameter int T_READ     = 12,
  parameter int T_PROG     = 20,
  parameter int T_ERASE    = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rb
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int T_MAX = (T_READ > T_PROG) ? ((T_READ > T_ERASE) ? T_READ : T_ERASE)
                                           : ((T_PROG > T_ERASE) ? T_PROG : T_ERASE);
  localparam int CNT_W = $clog2(T_MAX + 1);

  function automatic logic [1:0] addr_cycles(input phase_e p);
    case (p)
      PH_RD_ADDR, PH_PG_ADDR: return 2'd3;
      PH_ER_ADDR:             return 2'd2;
      default:                return 2'd0;
    endcase
  endfunction

  logic ev_cmd, ev_addr, ev_din, ev_rd;
  logic busy;
  phase_e phase_q;
  logic [1:0] acnt_q;
  logic half_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col;
  logic wrap;

  // named internal events
  logic cmd_take, addr_take, addr_extra, col_load, din_take, rd_take, col_step;
  logic go_read, go_prog, go_erase, tmr_start;
  logic [CNT_W-1:0] tmr_val;

  nand_bus_decode i_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n),
    .ev_cmd(ev_cmd), .ev_addr(ev_addr), .ev_din(ev_din), .ev_rd(ev_rd)
  );

  assign cmd_take   = ev_cmd & ~busy;
  assign addr_take  = ev_addr & ~busy & (acnt_q < addr_cycles(phase_q));
  assign addr_extra = ev_addr & ~busy & (acnt_q >= addr_cycles(phase_q));
  assign col_load   = addr_take & (acnt_q == 2'd0) &
                      (phase_q == PH_RD_ADDR || phase_q == PH_PG_ADDR);
  assign din_take   = ev_din & ~busy & (phase_q == PH_PG_DATA);
  assign rd_take    = ev_rd & ~busy & (phase_q == PH_RD_DATA);
  assign col_step   = din_take | rd_take;

  assign go_read  = addr_take & (phase_q == PH_RD_ADDR) & (acnt_q == 2'd2);
  assign go_prog  = cmd_take & wp_n & (io_in == OP_PROGRAM) & (phase_q == PH_PG_DATA);
  assign go_erase = cmd_take & wp_n & (io_in == OP_ERASE_GO) &
                    (phase_q == PH_ER_ADDR) & (acnt_q == 2'd2);
  assign tmr_start = go_read | go_prog | go_erase;
  assign tmr_val   = go_read ? CNT_W'(T_READ) : (go_prog ? CNT_W'(T_PROG) : CNT_W'(T_ERASE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      acnt_q  <= '0;
      half_q  <= 1'b0;
      row_q   <= '0;
    end else begin
      if (cmd_take) begin
        acnt_q <= '0;
        case (io_in)
          OP_READ_LO, OP_READ_HI: begin
            half_q  <= io_in[0];
            phase_q <= PH_RD_ADDR;
          end
          OP_LOAD:      phase_q <= wp_n ? PH_PG_ADDR : PH_IDLE;
          OP_ERASE_SET: phase_q <= wp_n ? PH_ER_ADDR : PH_IDLE;
          default:      phase_q <= PH_IDLE;
        endcase
      end else if (addr_take) begin
        acnt_q <= acnt_q + 1'b1;
        if (phase_q == PH_ER_ADDR) begin
          if (acnt_q == 2'd0) row_q[7:0] <= io_in;
          else                row_q[ROW_W-1:8] <= (ROW_W-8)'(io_in);
        end else begin
          if (acnt_q == 2'd1) row_q[7:0] <= io_in;
          if (acnt_q == 2'd2) row_q[ROW_W-1:8] <= (ROW_W-8)'(io_in);
        end
        if (acnt_q == 2'd2 && phase_q == PH_RD_ADDR) phase_q <= PH_RD_DATA;
        if (acnt_q == 2'd2 && phase_q == PH_PG_ADDR) phase_q <= PH_PG_DATA;
      end else if (wrap) begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  nand_col_ptr #(.PAGE_BYTES(PAGE_BYTES), .HALF_BYTES(HALF_BYTES), .COL_W(COL_W)) i_col (
    .clk(clk), .rst_n(rst_n), .load(col_load), .half(half_q), .lo(io_in),
    .step(col_step), .col(col), .wrap(wrap)
  );

  nand_busy_timer #(.CNT_W(CNT_W)) i_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .load_val(tmr_val), .busy(busy)
  );

  nand_page_buf #(.DEPTH(PAGE_BYTES), .AW(COL_W)) i_buf (
    .clk(clk), .rst_n(rst_n), .clear(go_erase), .wr_en(din_take), .rd_en(rd_take),
    .addr(col), .wdata(io_in), .rdata(io_out)
  );

  assign io_oe = ~ce_n & ~re_n & (phase_q == PH_RD_DATA) & ~busy;
  assign rb    = ~busy;

  // R6: no output is driven while busy
  a_r6_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !rb |-> !io_oe);

  // R4: surplus address cycles leave the pointer where it was
  a_r4_extra_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_extra && !col_step) |=> $stable(col));

  // R8: with write protect low, program/erase setup is never entered
  a_r8_wp_block: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && !wp_n) |=> (phase_q != PH_PG_ADDR && phase_q != PH_ER_ADDR));

  // R9: a column wrap moves to the next row
  a_r9_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !cmd_take && !addr_take) |=> row_q == $past(row_q) + 1'b1);
endmodule

// File: tb/test_nand_front_end.sv
module test_nand_front_end;
  localparam int PAGE    = 528;
  localparam int T_READ  = 12;
  localparam int T_PROG  = 20;
  localparam int T_ERASE = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic io_oe, rb;

  always #2.5 clk = ~clk;

  nand_front_end #(.T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE)) i_nand_front_end (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rb(rb)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] model [PAGE];
  int   ptr = 0;
  bit   bhalf = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic strobe = 1'b0;

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when the driver flags a data window
  always @(negedge clk) begin
    if (strobe && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (io_oe !== 1'b1 || io_out !== e) begin
        n_bad++;
        $display("FAIL %s: io_out=%h oe=%b expected %h oe=1", t, io_out, io_oe, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(logic c, logic a, logic [7:0] d);
    tick();
    cle = c; ale = a; io_in = d; we_n = 1'b0;
    tick();
    we_n = 1'b1;
    tick();
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(logic [7:0] d);  bus_wr(1'b1, 1'b0, d); endtask
  task automatic addr(logic [7:0] d); bus_wr(1'b0, 1'b1, d); endtask
  task automatic din(logic [7:0] d);  bus_wr(1'b0, 1'b0, d); endtask

  // counts busy cycles; exp < 0 only waits
  task automatic wait_ready(int exp, string req);
    int n = 0;
    @(negedge clk);
    while (!rb && n < 100000) begin
      n++;
      @(negedge clk);
    end
    if (exp >= 0) check(req, n, exp);
  endtask

  function automatic int col_of(bit h, logic [7:0] lo);
    return (h ? 256 : 0) + int'(lo);
  endfunction

  task automatic read_start(logic [7:0] code, logic [7:0] lo);
    cmd(code);
    bhalf = code[0];
    addr(lo); addr(8'h03); addr(8'h00);
    wait_ready(T_READ, "R7 read busy");
    ptr = col_of(bhalf, lo);
  endtask

  task automatic read_bytes(int n, string req);
    for (int i = 0; i < n; i++) begin
      tick();
      re_n = 1'b0;
      exp_q.push_back(model[ptr]);
      tag_q.push_back(req);
      ptr = (ptr == PAGE - 1) ? 0 : ptr + 1;
      tick();
      strobe = 1'b1;
      tick();
      strobe = 1'b0;
      re_n = 1'b1;
    end
  endtask

  task automatic program_seq(logic [7:0] lo, int n, logic [7:0] base, bit extra);
    int p;
    cmd(8'h80);
    addr(lo); addr(8'h03); addr(8'h00);
    if (extra) addr(8'h77);
    p = col_of(bhalf, lo);
    for (int i = 0; i < n; i++) begin
      din(base + 8'(i));
      if (wp_n) model[p] = base + 8'(i);
      p = (p == PAGE - 1) ? 0 : p + 1;
    end
    cmd(8'h10);
    wait_ready(wp_n ? T_PROG : 0, wp_n ? "R7 program busy" : "R8 program ignored");
  endtask

  task automatic erase_seq(bit raise_ce);
    cmd(8'h60); addr(8'h03); addr(8'h00); cmd(8'hD0);
    if (raise_ce) ce_n = 1'b1;
    if (wp_n && !ce_n) begin
      for (int i = 0; i < PAGE; i++) model[i] = 8'hFF;
    end else if (wp_n && raise_ce) begin
      for (int i = 0; i < PAGE; i++) model[i] = 8'hFF;
    end
    wait_ready((wp_n) ? T_ERASE : 0, wp_n ? "R7 erase busy, ce_n high" : "R8 erase ignored");
    ce_n = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    @(negedge clk);
    check("R1 rb after reset", rb, 1);
    check("R1 io_oe after reset", io_oe, 0);
    tick();
    rst_n = 1'b1;
    repeat (2) tick();

    // R10 erase to FFh, R7 busy with ce_n raised
    erase_seq(1'b1);
    read_start(8'h00, 8'h10);
    read_bytes(3, "R10 erased byte");

    // R10 program, R4 surplus address cycle, R2 first half
    cmd(8'h00); bhalf = 1'b0;
    program_seq(8'h05, 4, 8'hA0, 1'b1);
    read_start(8'h00, 8'h05);
    read_bytes(5, "R3 R4 sequential read");

    // R6 output disabled by ce_n, pointer held
    read_start(8'h00, 8'h05);
    tick(); ce_n = 1'b1; re_n = 1'b0;
    @(negedge clk);
    check("R6 io_oe with ce_n high", io_oe, 0);
    tick(); re_n = 1'b1; tick(); ce_n = 1'b0;
    read_bytes(2, "R6 pointer unchanged after deselected RE");

    // R6 output disabled while busy
    cmd(8'h00); addr(8'h06); addr(8'h03); addr(8'h00);
    re_n = 1'b0;
    @(negedge clk);
    check("R6 rb busy", rb, 0);
    check("R6 io_oe while busy", io_oe, 0);
    tick(); re_n = 1'b1;
    wait_ready(-1, "");
    ptr = 6; bhalf = 1'b0;
    read_bytes(1, "R3 first byte after busy");

    // R2 second half via 01h
    cmd(8'h01); bhalf = 1'b1;
    program_seq(8'h0E, 2, 8'h5A, 1'b0);
    read_start(8'h01, 8'h0E);
    read_bytes(2, "R2 second half start");
    read_start(8'h00, 8'h0E);
    read_bytes(1, "R2 first half same low byte");

    // R9 wrap past column 527
    cmd(8'h01); bhalf = 1'b1;
    program_seq(8'hFE, 20, 8'h30, 1'b0);
    read_start(8'h01, 8'hFE);
    read_bytes(21, "R9 wrap to column 0");

    // R5 write strobes ignored with ce_n high
    ce_n = 1'b1;
    cmd(8'h60); addr(8'h03); addr(8'h00); cmd(8'hD0);
    ce_n = 1'b0;
    wait_ready(0, "R5 deselected erase ignored");
    read_start(8'h00, 8'h05);
    read_bytes(2, "R5 page intact after deselected writes");

    // R8 write protect
    wp_n = 1'b0;
    erase_seq(1'b0);
    cmd(8'h00); bhalf = 1'b0;
    program_seq(8'h05, 2, 8'h11, 1'b0);
    read_start(8'h00, 8'h05);
    read_bytes(3, "R8 page unchanged under protect");
    wp_n = 1'b1;

    repeat (4) tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule